// File: doc/BRIEF.md
# GPIO Pad Register Bank

This block is the register file behind a bank of 95 general-purpose pins. A host reaches it through a plain 32-bit bus with word addresses: one write strobe, one read strobe, one address, and a registered read word. Two kinds of storage are mixed in one map. Bitmapped words pack 32 pins each and hold pin ownership, interrupt-controller routing, interrupt status and interrupt enable. Two configuration words per pin hold that pin's mode, direction, output level, trigger settings, pull choice and input-sense gate.

From that storage the bank drives the pad controls for every pin: output enable, output level, weak pull-up, weak pull-down and the input buffer enable. Pin inputs pass through a two-flop synchronizer. The result is gated by the per-pin sense enable, then read back through the bus and forwarded to a separate edge/level detection block. That block returns one event pulse per pin, which sets the matching status bit. Byte offsets in the map divide by four to give the word addresses listed below.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin's primary word reads 0x00000004 (mode 0 = native, direction input), every secondary word reads 0x00000004 (sensing off, no pull), all bitmapped words read 0, and no pin is driven, pulled or sensed.
- R2: Pin p occupies bit p mod 32 of word base + p/32 of each bitmapped register, with bases at word 0 (ownership), 4 (routing), 32 (status) and 36 (enable); these words are read/write except status.
- R3: The primary word of pin p sits at word 64 + 2p: bit 31 output level, bit 30 sampled input (read-only, writes ignored), bit 4 trigger kind (1 level, 0 edge), bit 3 trigger invert, bit 2 direction (1 input, 0 output), bits 1:0 mode (1 GPIO); det_kind_o and det_inv_o follow bits 4 and 3.
- R4: The secondary word of pin p sits at word 65 + 2p: bit 2 turns input sensing off, bits 1:0 select the pull (1 down, 2 up, 0 and 3 neither); all three bits read back.
- R5: pad_oe_o of a pin is high exactly when its mode is 1 and its direction bit is 0, and pad_out_o then carries the output level and is 0 otherwise; both change in the cycle after the write.
- R6: Each pad input is sampled through two flops; with sensing on, det_lvl_o and primary-word bit 30 show a new level after the second rising edge, and with sensing off both are 0.
- R7: A pulse on evt_i sets that pin's status bit; writing 1 to a status bit clears it, writing 0 leaves it, and an event in the same cycle as a clearing write wins.
- R8: Unused bits, unmapped addresses, bitmapped bits for pins 95 and above, and configuration words for pins 95 and above (word 254 onward) read 0 and writes to them change nothing.
- R9: Read data appears on rdata_o in the cycle after rd_en_i and holds until the next read; a read and a write to the same word in one cycle return the old value.
- R10: Word 31 is a global control word whose bit 0 is stored and read back; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 95 | Raw pad input levels |
| pad_out_o | output | 95 | Pad output level |
| pad_oe_o | output | 95 | Pad output enable |
| pull_up_o | output | 95 | Weak pull-up enable |
| pull_dn_o | output | 95 | Weak pull-down enable |
| sense_en_o | output | 95 | Input buffer enable |
| det_lvl_o | output | 95 | Synchronized, gated level to the detection block |
| det_kind_o | output | 95 | Trigger kind per pin (1 level) |
| det_inv_o | output | 95 | Trigger invert per pin |
| evt_i | input | 95 | Per-pin event pulses from the detection block |

## Verification
The hardest case to reach is the collision in the status word: an event pulse and a clearing write must land on the same bit in the same clock edge. The stimulus holds evt_i and the write strobe together across one edge, then reads the word back. Reaching the synchronizer boundary also needs care: the stimulus changes one pad between edges and samples det_lvl_o after the first edge and again after the second. Configuration addresses just past the last pin are written with values that would drive a pad if they aliased onto a real pin, and the outputs are checked for that.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W    = 32;
    localparam int MAP_WORDS = 4;   // word slots reserved per bitmapped register

    // word addresses (byte offset / 4)
    localparam int OWN_BASE   = 0;
    localparam int ROUTE_BASE = 4;
    localparam int GCTL_ADDR  = 31;
    localparam int STAT_BASE  = 32;
    localparam int EN_BASE    = 36;
    localparam int CFG_BASE   = 64;

    localparam logic [1:0] MODE_GPIO = 2'd1;
    localparam logic [1:0] PULL_DN   = 2'd1;
    localparam logic [1:0] PULL_UP   = 2'd2;

    typedef enum logic [2:0] {
        K_NONE,
        K_OWN,
        K_ROUTE,
        K_GCTL,
        K_STAT,
        K_EN,
        K_CFG_A,
        K_CFG_B
    } reg_kind_e;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic [1:0] mode;
    } cfg_a_t;

    typedef struct packed {
        logic       sense_off;
        logic [1:0] pull;
    } cfg_b_t;

    localparam cfg_a_t CFG_A_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                     dir_in: 1'b1, mode: 2'b00};
    localparam cfg_b_t CFG_B_RST = '{sense_off: 1'b1, pull: 2'b00};

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_pad_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_PINS = 95,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [1:0]        widx_o,
    output logic [PIN_W-1:0]  pin_o
);

    logic [ADDR_W-1:0] cfg_off;
    logic [ADDR_W-2:0] cfg_pin;

    always_comb begin
        kind_o  = K_NONE;
        widx_o  = addr_i[1:0];
        pin_o   = '0;
        cfg_off = addr_i - ADDR_W'(CFG_BASE);
        cfg_pin = cfg_off[ADDR_W-1:1];
        if (addr_i >= ADDR_W'(CFG_BASE)) begin
            if (int'(cfg_pin) < NUM_PINS) begin
                kind_o = cfg_off[0] ? K_CFG_B : K_CFG_A;
                pin_o  = cfg_pin[PIN_W-1:0];
            end
        end else if (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(OWN_BASE / 4)) begin
            kind_o = K_OWN;
        end else if (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(ROUTE_BASE / 4)) begin
            kind_o = K_ROUTE;
        end else if (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(STAT_BASE / 4)) begin
            kind_o = K_STAT;
        end else if (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(EN_BASE / 4)) begin
            kind_o = K_EN;
        end else if (addr_i == ADDR_W'(GCTL_ADDR)) begin
            kind_o = K_GCTL;
        end
    end

endmodule

// File: rtl/gpio_pad_rdmux.sv
module gpio_pad_rdmux
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS = 95,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  reg_kind_e                   kind_i,
    input  logic [1:0]                  widx_i,
    input  logic [PIN_W-1:0]            pin_i,
    input  logic [NUM_PINS-1:0]         own_i,
    input  logic [NUM_PINS-1:0]         route_i,
    input  logic [NUM_PINS-1:0]         stat_i,
    input  logic [NUM_PINS-1:0]         en_i,
    input  logic                        gctl_i,
    input  cfg_a_t [NUM_PINS-1:0]       cfg_a_i,
    input  cfg_b_t [NUM_PINS-1:0]       cfg_b_i,
    input  logic [NUM_PINS-1:0]         sensed_i,
    output logic [WORD_W-1:0]           word_o
);

    localparam int PAD_W = MAP_WORDS * WORD_W;

    logic [PAD_W-1:0] own_w, route_w, stat_w, en_w;

    // widen each bitmap to whole words; bits past the last pin are tied low
    for (genvar b = 0; b < PAD_W; b++) begin : g_pad
        if (b < NUM_PINS) begin : g_live
            assign own_w[b]   = own_i[b];
            assign route_w[b] = route_i[b];
            assign stat_w[b]  = stat_i[b];
            assign en_w[b]    = en_i[b];
        end else begin : g_dead
            assign own_w[b]   = 1'b0;
            assign route_w[b] = 1'b0;
            assign stat_w[b]  = 1'b0;
            assign en_w[b]    = 1'b0;
        end
    end

    logic [6:0] wsel;
    assign wsel = {widx_i, 5'b00000};

    always_comb begin
        word_o = '0;
        case (kind_i)
            K_OWN:   word_o = own_w[wsel +: WORD_W];
            K_ROUTE: word_o = route_w[wsel +: WORD_W];
            K_STAT:  word_o = stat_w[wsel +: WORD_W];
            K_EN:    word_o = en_w[wsel +: WORD_W];
            K_GCTL:  word_o = {31'b0, gctl_i};
            K_CFG_A: word_o = {cfg_a_i[pin_i].out_lvl, sensed_i[pin_i], 25'b0,
                               cfg_a_i[pin_i].trig_lvl, cfg_a_i[pin_i].trig_inv,
                               cfg_a_i[pin_i].dir_in, cfg_a_i[pin_i].mode};
            K_CFG_B: word_o = {29'b0, cfg_b_i[pin_i]};
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_PINS = 95
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pull_up_o,
    output logic [NUM_PINS-1:0] pull_dn_o,
    output logic [NUM_PINS-1:0] sense_en_o,
    output logic [NUM_PINS-1:0] det_lvl_o,
    output logic [NUM_PINS-1:0] det_kind_o,
    output logic [NUM_PINS-1:0] det_inv_o,
    input  logic [NUM_PINS-1:0] evt_i
);

    localparam int PIN_W = $clog2(NUM_PINS);

    typedef struct packed {
        cfg_a_t [NUM_PINS-1:0] cfg_a;
        cfg_b_t [NUM_PINS-1:0] cfg_b;
        logic   [NUM_PINS-1:0] own;
        logic   [NUM_PINS-1:0] route;
        logic   [NUM_PINS-1:0] stat;
        logic   [NUM_PINS-1:0] en;
        logic                  gctl;
        logic   [31:0]         rdata;
    } bank_t;

    function automatic bank_t bank_reset();
        bank_t b;
        b = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            b.cfg_a[p] = CFG_A_RST;
            b.cfg_b[p] = CFG_B_RST;
        end
        return b;
    endfunction

    bank_t              st_d, st_q;
    reg_kind_e          kind;
    logic [1:0]         widx;
    logic [PIN_W-1:0]   pin;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] sensed;
    logic [31:0]        rd_word;

    gpio_pad_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PINS (NUM_PINS)
    ) decode_i (
        .addr_i (addr_i),
        .kind_o (kind),
        .widx_o (widx),
        .pin_o  (pin)
    );

    gpio_pad_sync #(
        .WIDTH (NUM_PINS)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_in_i),
        .q_o    (sync_lvl)
    );

    gpio_pad_rdmux #(
        .NUM_PINS (NUM_PINS)
    ) rdmux_i (
        .kind_i   (kind),
        .widx_i   (widx),
        .pin_i    (pin),
        .own_i    (st_q.own),
        .route_i  (st_q.route),
        .stat_i   (st_q.stat),
        .en_i     (st_q.en),
        .gctl_i   (st_q.gctl),
        .cfg_a_i  (st_q.cfg_a),
        .cfg_b_i  (st_q.cfg_b),
        .sensed_i (sensed),
        .word_o   (rd_word)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (kind)
                K_OWN: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (widx == 2'(p / 32)) st_d.own[p] = wdata_i[p % 32];
                    end
                end
                K_ROUTE: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (widx == 2'(p / 32)) st_d.route[p] = wdata_i[p % 32];
                    end
                end
                K_EN: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (widx == 2'(p / 32)) st_d.en[p] = wdata_i[p % 32];
                    end
                end
                K_STAT: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (widx == 2'(p / 32) && wdata_i[p % 32]) st_d.stat[p] = 1'b0;
                    end
                end
                K_GCTL: st_d.gctl = wdata_i[0];
                K_CFG_A: st_d.cfg_a[pin] = '{out_lvl:  wdata_i[31],
                                            trig_lvl: wdata_i[4],
                                            trig_inv: wdata_i[3],
                                            dir_in:   wdata_i[2],
                                            mode:     wdata_i[1:0]};
                K_CFG_B: st_d.cfg_b[pin] = '{sense_off: wdata_i[2],
                                            pull:      wdata_i[1:0]};
                default: ;
            endcase
        end
        // a new event outranks a clearing write in the same cycle
        st_d.stat = st_d.stat | evt_i;
        if (rd_en_i) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= bank_reset();
        else         st_q <= st_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pad_oe_o[p]   = (st_q.cfg_a[p].mode == MODE_GPIO) && !st_q.cfg_a[p].dir_in;
        assign pad_out_o[p]  = pad_oe_o[p] & st_q.cfg_a[p].out_lvl;
        assign pull_up_o[p]  = (st_q.cfg_b[p].pull == PULL_UP);
        assign pull_dn_o[p]  = (st_q.cfg_b[p].pull == PULL_DN);
        assign sense_en_o[p] = !st_q.cfg_b[p].sense_off;
        assign sensed[p]     = sync_lvl[p] & sense_en_o[p];
        assign det_kind_o[p] = st_q.cfg_a[p].trig_lvl;
        assign det_inv_o[p]  = st_q.cfg_a[p].trig_inv;
    end

    assign det_lvl_o = sensed;
    assign rdata_o   = st_q.rdata;

endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int NUM_PINS = 95
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_en_i,
    input logic                rd_en_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [31:0]         wdata_i,
    input logic [31:0]         rdata_o,
    input logic [NUM_PINS-1:0] pad_in_i,
    input logic [NUM_PINS-1:0] pad_out_o,
    input logic [NUM_PINS-1:0] pad_oe_o,
    input logic [NUM_PINS-1:0] sense_en_o,
    input logic [NUM_PINS-1:0] det_lvl_o
);

    localparam int PIN_W = $clog2(NUM_PINS);

    logic              unused_bits;
    logic [1:0]        age_q;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-2:0] cpin;
    logic              cfg_a_hit;
    logic              gap_hit;
    logic [PIN_W-1:0]  pin_c;

    assign unused_bits = ^wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    always_comb begin
        off       = addr_i - ADDR_W'(64);
        cpin      = off[ADDR_W-1:1];
        cfg_a_hit = (addr_i >= ADDR_W'(64)) && !off[0] && (int'(cpin) < NUM_PINS);
        pin_c     = cfg_a_hit ? cpin[PIN_W-1:0] : '0;
        gap_hit   = ((addr_i >= ADDR_W'(8)) && (addr_i <= ADDR_W'(30))) ||
                    ((addr_i >= ADDR_W'(40)) && (addr_i < ADDR_W'(64)));
    end

    // R9: read data only moves on a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

    // R6: two-flop delay and sense gating seen at the detection output
    a_r6_sync_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (det_lvl_o == ($past(pad_in_i, 2) & sense_en_o)));

    // R6: bus view of the input bit agrees with the detection feed
    a_r6_rd_in_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && cfg_a_hit) |=> (rdata_o[30] == $past(det_lvl_o[pin_c])));

    // R5: output enable follows mode and direction of the written word
    a_r5_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && cfg_a_hit) |=>
        (pad_oe_o[$past(pin_c)] == $past((wdata_i[1:0] == 2'b01) && !wdata_i[2])));

    // R5: driven level appears only on an enabled pin
    a_r5_out_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && cfg_a_hit) |=>
        (pad_out_o[$past(pin_c)] == $past((wdata_i[1:0] == 2'b01) && !wdata_i[2] && wdata_i[31])));

    // R8: unmapped word addresses read zero
    a_r8_gap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && gap_hit) |=> (rdata_o == 32'h0));

endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_PINS (NUM_PINS)
) chk_i (.*);

// File: tb/gpio_pad_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb_top;

    localparam int ADDR_W = 8;
    localparam int NP     = 95;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [NP-1:0]     pad_out, pad_oe, pull_up, pull_dn, sense_en, det_lvl, det_kind, det_inv;
    logic [NP-1:0]     evt = '0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_pad_bank #(.ADDR_W(ADDR_W), .NUM_PINS(NP)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .pad_in_i   (pad_in),
        .pad_out_o  (pad_out),
        .pad_oe_o   (pad_oe),
        .pull_up_o  (pull_up),
        .pull_dn_o  (pull_dn),
        .sense_en_o (sense_en),
        .det_lvl_o  (det_lvl),
        .det_kind_o (det_kind),
        .det_inv_o  (det_inv),
        .evt_i      (evt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] mon_e;
    string       mon_t;

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 scoreboard: rdata=%h expected no read", rdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (rdata !== mon_e) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", mon_t, rdata, mon_e);
                end
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_rw(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic [31:0] e_old, input string t);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(e_old);
        tag_q.push_back(t);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 no pin driven", {31'b0, |pad_oe}, 32'h0);
        chk("R1 no pull", {30'b0, |pull_up, |pull_dn}, 32'h0);
        chk("R1 sensing off", {31'b0, |sense_en}, 32'h0);
        bus_rd(8'd74, 32'h4, "R1 primary word reset");
        bus_rd(8'd75, 32'h4, "R1 secondary word reset");
        bus_rd(8'd37, 32'h0, "R1 enable word reset");
        bus_rd(8'd0,  32'h0, "R1 ownership word reset");

        // R2 bitmapped words
        bus_wr(8'd2, 32'hFFFF_FFFF);
        bus_rd(8'd2, 32'h7FFF_FFFF, "R2 ownership top word");
        bus_wr(8'd4, 32'hA5A5_A5A5);
        bus_rd(8'd4, 32'hA5A5_A5A5, "R2 routing word 0");
        bus_rd(8'd5, 32'h0, "R2 routing word 1 untouched");
        bus_wr(8'd37, 32'h0001_0000);
        bus_rd(8'd37, 32'h0001_0000, "R2 enable word 1");
        bus_rd(8'd36, 32'h0, "R2 enable word 0 untouched");

        // R8 unmapped and out-of-range
        bus_wr(8'd3, 32'hFFFF_FFFF);
        bus_rd(8'd3, 32'h0, "R8 ownership word past pins");
        bus_wr(8'd254, 32'hFFFF_FFFF);
        bus_rd(8'd254, 32'h0, "R8 pin 95 primary");
        bus_rd(8'd255, 32'h0, "R8 pin 95 secondary");
        bus_wr(8'd254, 32'h0000_0001);
        chk("R8 pin 95 write drives nothing", {31'b0, |pad_oe}, 32'h0);
        bus_wr(8'd20, 32'hFFFF_FFFF);
        bus_rd(8'd20, 32'h0, "R8 gap word");
        bus_rd(8'd252, 32'h4, "R8 last pin still at reset");

        // R3 primary word layout
        bus_wr(8'd78, 32'hFFFF_FFFF);
        bus_rd(8'd78, 32'h8000_001F, "R3 primary fields, input bit read-only");
        chk("R3 trigger kind/invert out", {30'b0, det_kind[7], det_inv[7]}, 32'h3);
        chk("R5 mode 3 not driven", {31'b0, pad_oe[7]}, 32'h0);

        // R5 drive enable
        bus_wr(8'd78, 32'h8000_0001);
        chk("R5 gpio output high", {30'b0, pad_oe[7], pad_out[7]}, 32'h3);
        chk("R5 only pin 7 driven", {31'b0, pad_oe == (NP'(1) << 7)}, 32'h1);
        bus_wr(8'd78, 32'h0000_0001);
        chk("R5 gpio output low", {30'b0, pad_oe[7], pad_out[7]}, 32'h2);
        bus_wr(8'd78, 32'h8000_0005);
        chk("R5 gpio input", {30'b0, pad_oe[7], pad_out[7]}, 32'h0);
        bus_wr(8'd78, 32'h8000_0000);
        chk("R5 native output", {30'b0, pad_oe[7], pad_out[7]}, 32'h0);

        // R4 secondary word
        bus_wr(8'd79, 32'h2);
        chk("R4 pull-up", {29'b0, pull_up[7], pull_dn[7], sense_en[7]}, 32'h5);
        bus_rd(8'd79, 32'h2, "R4 readback pull-up");
        bus_wr(8'd79, 32'h1);
        chk("R4 pull-down", {29'b0, pull_up[7], pull_dn[7], sense_en[7]}, 32'h3);
        bus_wr(8'd79, 32'hFFFF_FFFF);
        bus_rd(8'd79, 32'h7, "R4 readback all fields");
        chk("R4 code 3 no pull, sensing off", {29'b0, pull_up[7], pull_dn[7], sense_en[7]}, 32'h0);

        // R6 synchronizer and gating, pin 10
        bus_wr(8'd85, 32'h0);
        @(negedge clk);
        pad_in[10] = 1'b1;
        @(negedge clk);
        chk("R6 level not through after one edge", {31'b0, det_lvl[10]}, 32'h0);
        @(negedge clk);
        chk("R6 level through after two edges", {31'b0, det_lvl[10]}, 32'h1);
        bus_rd(8'd84, 32'h4000_0004, "R6 input bit high");
        bus_wr(8'd85, 32'h4);
        chk("R6 gated when sensing off", {31'b0, det_lvl[10]}, 32'h0);
        bus_rd(8'd84, 32'h4, "R6 input bit gated");
        pad_in[10] = 1'b0;
        bus_wr(8'd85, 32'h0);
        repeat (3) @(negedge clk);
        bus_wr(8'd84, 32'h4000_0004);
        bus_rd(8'd84, 32'h4, "R3 write to input bit ignored");

        // R7 status, pin 40 = word 33 bit 8
        @(negedge clk); evt[40] = 1'b1;
        @(negedge clk); evt[40] = 1'b0;
        bus_rd(8'd33, 32'h100, "R7 event sets status");
        bus_wr(8'd33, 32'h0);
        bus_rd(8'd33, 32'h100, "R7 zero write keeps status");
        bus_wr(8'd33, 32'h100);
        bus_rd(8'd33, 32'h0, "R7 one write clears status");
        @(negedge clk);
        evt[40] = 1'b1; addr = 8'd33; wdata = 32'h100; wr_en = 1'b1;
        @(negedge clk);
        evt[40] = 1'b0; wr_en = 1'b0;
        bus_rd(8'd33, 32'h100, "R7 event wins over clear");

        // R10 global word
        bus_wr(8'd31, 32'hFFFF_FFFF);
        bus_rd(8'd31, 32'h1, "R10 global bit 0 only");

        // R9 read timing, pin 20 secondary word = 105
        bus_rw(8'd105, 32'h2, 32'h4, "R9 same-cycle read gives old value");
        bus_rd(8'd105, 32'h2, "R9 new value after write");
        repeat (3) @(negedge clk);
        chk("R9 rdata holds between reads", rdata, 32'h2);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule